// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block forms the operand address for the three indexed addressing forms of an 8-bit processor. A sequencer pulses a start input together with a two-bit form selector and the current index register byte. Depending on the form, the block then collects zero, one or two offset bytes from the instruction stream. It accepts a byte only in a cycle where the byte-valid input is high. When it has enough bytes, it presents a 16-bit effective address, the instruction length in bytes and a one-cycle done strobe.

The instruction length output lets the program counter logic step past the opcode and its offset bytes. The form without an offset reaches only page zero. The 8-bit offset form is an unsigned 9-bit sum, so its highest address is 0x01FE. The 16-bit offset form arrives most significant byte first, and its sum wraps at 64K. Selector value 3 is not a valid form. It produces an error strobe and no address.

Top module: `idx_ea_gen`

## Requirements
- R1: Selector 2'b00 (no offset) reads no bytes. In the cycle after start, done is high, ea equals {8'h00, index} and len equals 1.
- R2: Selector 2'b01 (byte offset) reads one byte. ea equals index plus that byte as a 9-bit unsigned sum, zero-extended, so it never exceeds 0x01FE. len equals 2.
- R3: Selector 2'b10 (word offset) reads two bytes, upper byte first. ea equals (index + {upper, lower}) modulo 65536, and len equals 3.
- R4: Selector 2'b11 is reserved. In the cycle after start, err is high for one cycle and done stays low. The block then takes a new start.
- R5: A cycle in which byte-valid is low while bytes are awaited consumes nothing and raises no done. Done appears in the cycle after the edge that samples the last byte.
- R6: Done and err are each high for a single cycle per request and are never high together.
- R7: A start that arrives while bytes are still awaited is ignored. A byte-valid that arrives while idle is ignored and leaves ea unchanged.
- R8: The selector and index are captured at start. Changing them afterwards does not affect the result.
- R9: A synchronous reset abandons any partly collected offset and clears done, err, ea and len to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a request (taken only when idle) |
| mode_i | input | 2 | Form selector: 00 none, 01 byte offset, 10 word offset, 11 reserved |
| index_i | input | 8 | Index register value |
| byte_valid_i | input | 1 | Offset byte present on byte_i |
| byte_i | input | 8 | Offset byte from the instruction stream |
| ea_o | output | 16 | Effective address, held until the next completion |
| len_o | output | 2 | Instruction length in bytes (1 to 3), held with ea_o |
| done_o | output | 1 | One-cycle strobe: ea_o and len_o are new |
| err_o | output | 1 | One-cycle strobe: reserved selector seen |

## Verification
Every result is registered once. The no-offset done and the reserved-selector err appear one cycle after the start edge. The offset-form done appears one cycle after the edge that samples the final valid byte, and done falls again the cycle after that. The bench drives and samples on the falling edge. It advances exactly one cycle per start or per byte edge, so each check lands in the single cycle where its result is due. It also checks done stays low in every stall cycle and in every cycle after a strobe.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;
    typedef enum logic [1:0] {
        MODE_NOOFF = 2'b00,
        MODE_OFF8  = 2'b01,
        MODE_OFF16 = 2'b10,
        MODE_RSVD  = 2'b11
    } ea_mode_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } ea_state_e;
endpackage

// File: rtl/ea_mode_decode.sv
module ea_mode_decode
    import idx_ea_pkg::*;
#(
    parameter int CNT_W = 2,
    parameter int LEN_W = 2
) (
    input  ea_mode_e             mode,
    output logic [CNT_W-1:0]     need_bytes,
    output logic [LEN_W-1:0]     instr_len,
    output logic                 reserved
);
    always_comb begin
        need_bytes = '0;
        instr_len  = LEN_W'(1);
        reserved   = 1'b0;
        case (mode)
            MODE_NOOFF: begin
                need_bytes = '0;
                instr_len  = LEN_W'(1);
            end
            MODE_OFF8: begin
                need_bytes = CNT_W'(1);
                instr_len  = LEN_W'(2);
            end
            MODE_OFF16: begin
                need_bytes = CNT_W'(2);
                instr_len  = LEN_W'(3);
            end
            default: begin
                reserved   = 1'b1;
                instr_len  = '0;
            end
        endcase
    end
endmodule

// File: rtl/ea_sum.sv
module ea_sum
    import idx_ea_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16
) (
    input  ea_mode_e             mode,
    input  logic [DATA_W-1:0]    index,
    input  logic [ADDR_W-1:0]    offset,
    output logic [ADDR_W-1:0]    ea
);
    localparam int PAD_IDX = ADDR_W - DATA_W;
    localparam int PAD_S8  = ADDR_W - DATA_W - 1;

    logic [DATA_W:0]   sum8;
    logic [ADDR_W-1:0] idx_ext;

    assign idx_ext = {{PAD_IDX{1'b0}}, index};
    assign sum8    = {1'b0, index} + {1'b0, offset[DATA_W-1:0]};

    always_comb begin
        case (mode)
            MODE_NOOFF: ea = idx_ext;
            MODE_OFF8:  ea = {{PAD_S8{1'b0}}, sum8};
            MODE_OFF16: ea = offset + idx_ext;
            default:    ea = '0;
        endcase
    end
endmodule

// File: rtl/idx_ea_gen.sv
module idx_ea_gen
    import idx_ea_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 2,
    parameter int CNT_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic [1:0]              mode_i,
    input  logic [DATA_W-1:0]       index_i,
    input  logic                    byte_valid_i,
    input  logic [DATA_W-1:0]       byte_i,
    output logic [2*DATA_W-1:0]     ea_o,
    output logic [LEN_W-1:0]        len_o,
    output logic                    done_o,
    output logic                    err_o
);
    localparam int ADDR_W = 2 * DATA_W;

    typedef struct packed {
        ea_state_e           state;
        ea_mode_e            mode;
        logic [DATA_W-1:0]   index;
        logic [ADDR_W-1:0]   offset;
        logic [CNT_W-1:0]    need;
        logic [CNT_W-1:0]    got;
        logic [LEN_W-1:0]    len_hold;
        logic [ADDR_W-1:0]   ea;
        logic [LEN_W-1:0]    len;
        logic                done;
        logic                err;
    } ea_regs_t;

    ea_regs_t r_q, r_d;

    logic [CNT_W-1:0]  dec_need;
    logic [LEN_W-1:0]  dec_len;
    logic              dec_rsvd;
    ea_mode_e          sum_mode;
    logic [DATA_W-1:0] sum_index;
    logic [ADDR_W-1:0] sum_offset;
    logic [ADDR_W-1:0] sum_ea;
    logic [ADDR_W-1:0] offset_shift;
    logic              fetch_w;

    assign fetch_w      = (r_q.state == ST_FETCH);
    assign offset_shift = {r_q.offset[ADDR_W-DATA_W-1:0], byte_i};

    ea_mode_decode #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_dec (
        .mode       (ea_mode_e'(mode_i)),
        .need_bytes (dec_need),
        .instr_len  (dec_len),
        .reserved   (dec_rsvd)
    );

    assign sum_mode   = fetch_w ? r_q.mode  : ea_mode_e'(mode_i);
    assign sum_index  = fetch_w ? r_q.index : index_i;
    assign sum_offset = fetch_w ? offset_shift : '0;

    ea_sum #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_sum (
        .mode   (sum_mode),
        .index  (sum_index),
        .offset (sum_offset),
        .ea     (sum_ea)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.mode     = ea_mode_e'(mode_i);
                    r_d.index    = index_i;
                    r_d.need     = dec_need;
                    r_d.len_hold = dec_len;
                    r_d.got      = '0;
                    r_d.offset   = '0;
                    if (dec_rsvd) begin
                        r_d.err = 1'b1;
                    end else if (dec_need == '0) begin
                        r_d.done = 1'b1;
                        r_d.ea   = sum_ea;
                        r_d.len  = dec_len;
                    end else begin
                        r_d.state = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                if (byte_valid_i) begin
                    r_d.offset = offset_shift;
                    r_d.got    = r_q.got + CNT_W'(1);
                    if (r_q.got + CNT_W'(1) == r_q.need) begin
                        r_d.done  = 1'b1;
                        r_d.ea    = sum_ea;
                        r_d.len   = r_q.len_hold;
                        r_d.state = ST_IDLE;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{state: ST_IDLE, mode: MODE_NOOFF, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ea_o   = r_q.ea;
    assign len_o  = r_q.len;
    assign done_o = r_q.done;
    assign err_o  = r_q.err;
endmodule

// File: rtl/idx_ea_gen_chk.sv
module idx_ea_gen_chk #(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 start_i,
    input logic [1:0]           mode_i,
    input logic [DATA_W-1:0]    index_i,
    input logic                 byte_valid_i,
    input logic [2*DATA_W-1:0]  ea_o,
    input logic [LEN_W-1:0]     len_o,
    input logic                 done_o,
    input logic                 err_o,
    input logic                 fetch_w
);
    localparam int ADDR_W = 2 * DATA_W;

    // R1: a no-offset start completes next cycle with page-zero address
    p_nooff_next_r1: assert property (@(posedge clk) disable iff (rst)
        (start_i && !fetch_w && mode_i == 2'b00) |=>
            (done_o && len_o == LEN_W'(1) &&
             ea_o == {{(ADDR_W-DATA_W){1'b0}}, $past(index_i)}));

    // R1: any length-1 result lies in page zero
    p_hi_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (done_o && len_o == LEN_W'(1)) |-> (ea_o[ADDR_W-1:DATA_W] == '0));

    // R2: byte-offset results never pass 0x01FE
    p_ceiling_r2: assert property (@(posedge clk) disable iff (rst)
        (done_o && len_o == LEN_W'(2)) |-> (ea_o <= ADDR_W'(16'h01FE)));

    // R3: a completed request reports a length of 1 to 3
    p_len_range_r3: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (len_o != '0));

    // R4: reserved selector gives err next cycle and no done
    p_rsvd_err_r4: assert property (@(posedge clk) disable iff (rst)
        (start_i && !fetch_w && mode_i == 2'b11) |=> (err_o && !done_o));

    // R5: a stalled byte cycle produces no done
    p_stall_r5: assert property (@(posedge clk) disable iff (rst)
        (fetch_w && !byte_valid_i) |=> !done_o);

    // R6: strobes are exclusive
    p_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(done_o && err_o));

    // R7: start during collection raises nothing by itself
    p_busy_start_r7: assert property (@(posedge clk) disable iff (rst)
        (fetch_w && start_i && !byte_valid_i) |=> (!done_o && !err_o));
endmodule

bind idx_ea_gen idx_ea_gen_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .mode_i       (mode_i),
    .index_i      (index_i),
    .byte_valid_i (byte_valid_i),
    .ea_o         (ea_o),
    .len_o        (len_o),
    .done_o       (done_o),
    .err_o        (err_o),
    .fetch_w      (fetch_w)
);

// File: tb/idx_ea_gen_bench.sv
module idx_ea_gen_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic [7:0]  index_i = 8'h00;
    logic        byte_valid_i = 1'b0;
    logic [7:0]  byte_i = 8'h00;
    logic [15:0] ea_o;
    logic [1:0]  len_o;
    logic        done_o;
    logic        err_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    idx_ea_gen u_idx_ea_gen (
        .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
        .index_i(index_i), .byte_valid_i(byte_valid_i), .byte_i(byte_i),
        .ea_o(ea_o), .len_o(len_o), .done_o(done_o), .err_o(err_o)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [7:0]  idx;
        logic [7:0]  b0;
        logic [7:0]  b1;
        logic [1:0]  gap;
        logic [15:0] ea;
        logic [1:0]  len;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{2'b00, 8'h00, 8'h00, 8'h00, 2'd0, 16'h0000, 2'd1},
        '{2'b00, 8'hFF, 8'h00, 8'h00, 2'd0, 16'h00FF, 2'd1},
        '{2'b01, 8'hFF, 8'hFF, 8'h00, 2'd0, 16'h01FE, 2'd2},
        '{2'b01, 8'h10, 8'h20, 8'h00, 2'd2, 16'h0030, 2'd2},
        '{2'b01, 8'h80, 8'h80, 8'h00, 2'd1, 16'h0100, 2'd2},
        '{2'b10, 8'h05, 8'h12, 8'h34, 2'd0, 16'h1239, 2'd3},
        '{2'b10, 8'hFF, 8'hFF, 8'hFF, 2'd1, 16'h00FE, 2'd3},
        '{2'b10, 8'h01, 8'h00, 8'hFF, 2'd3, 16'h0100, 2'd3},
        '{2'b10, 8'h00, 8'hAB, 8'hCD, 2'd2, 16'hABCD, 2'd3}
    };

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_req(input vec_t v, input string req);
        int nb;
        nb = (v.mode == 2'b00) ? 0 : (v.mode == 2'b01) ? 1 : 2;
        @(negedge clk);
        start_i = 1'b1; mode_i = v.mode; index_i = v.idx; byte_valid_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0; mode_i = 2'b11; index_i = ~v.idx;   // R8: disturb after capture
        for (int k = 0; k < nb; k++) begin
            for (int g = 0; g < int'(v.gap); g++) begin
                byte_valid_i = 1'b0; byte_i = 8'h5A;
                @(negedge clk);
                chk(done_o == 1'b0, "R5 stall no done", done_o, 0);
            end
            byte_valid_i = 1'b1; byte_i = (k == 0) ? v.b0 : v.b1;
            @(negedge clk);
            byte_valid_i = 1'b0;
            if (k < nb - 1) chk(done_o == 1'b0, "R5 early done", done_o, 0);
        end
        chk(done_o == 1'b1, {req, " done"}, done_o, 1);
        chk(ea_o == v.ea, {req, " ea"}, ea_o, v.ea);
        chk(len_o == v.len, {req, " len"}, len_o, v.len);
        chk(err_o == 1'b0, "R6 no err with done", err_o, 0);
        @(negedge clk);
        chk(done_o == 1'b0, "R6 done one cycle", done_o, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        vec_t v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        chk(done_o == 1'b0 && err_o == 1'b0, "R9 reset strobes", {done_o, err_o}, 0);
        chk(ea_o == 16'h0 && len_o == 2'd0, "R9 reset outputs", ea_o, 0);

        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            do_req(v, (v.mode == 2'b00) ? "R1" : (v.mode == 2'b01) ? "R2" : "R3");
        end

        // R4: reserved selector
        @(negedge clk);
        start_i = 1'b1; mode_i = 2'b11; index_i = 8'h42;
        @(negedge clk);
        start_i = 1'b0;
        chk(err_o == 1'b1, "R4 err raised", err_o, 1);
        chk(done_o == 1'b0, "R4 no done", done_o, 0);
        @(negedge clk);
        chk(err_o == 1'b0, "R4 err one cycle", err_o, 0);
        v = '{2'b01, 8'h03, 8'h04, 8'h00, 2'd0, 16'h0007, 2'd2};
        do_req(v, "R4 recovery");

        // R7: start while collecting is ignored
        @(negedge clk);
        start_i = 1'b1; mode_i = 2'b01; index_i = 8'h10;
        @(negedge clk);
        mode_i = 2'b00; index_i = 8'h77;
        @(negedge clk);
        start_i = 1'b0;
        chk(done_o == 1'b0 && err_o == 1'b0, "R7 busy start ignored", {done_o, err_o}, 0);
        byte_valid_i = 1'b1; byte_i = 8'h22;
        @(negedge clk);
        byte_valid_i = 1'b0;
        chk(done_o == 1'b1 && ea_o == 16'h0032, "R7 original request", ea_o, 16'h0032);
        chk(len_o == 2'd2, "R7 len", len_o, 2);

        // R7: bytes while idle are ignored
        @(negedge clk);
        byte_valid_i = 1'b1; byte_i = 8'h99;
        repeat (3) begin
            @(negedge clk);
            chk(done_o == 1'b0 && ea_o == 16'h0032, "R7 idle byte ignored", ea_o, 16'h0032);
        end
        byte_valid_i = 1'b0;
        v = '{2'b01, 8'h01, 8'h05, 8'h00, 2'd0, 16'h0006, 2'd2};
        do_req(v, "R7 after idle bytes");

        // R9: reset mid-collection
        @(negedge clk);
        start_i = 1'b1; mode_i = 2'b10; index_i = 8'h00;
        @(negedge clk);
        start_i = 1'b0; byte_valid_i = 1'b1; byte_i = 8'hAA;
        @(negedge clk);
        byte_valid_i = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(done_o == 1'b0 && err_o == 1'b0, "R9 strobes cleared", {done_o, err_o}, 0);
        chk(ea_o == 16'h0 && len_o == 2'd0, "R9 outputs cleared", ea_o, 0);
        v = '{2'b10, 8'h00, 8'h00, 8'h01, 2'd1, 16'h0001, 2'd3};
        do_req(v, "R9 fresh after abort");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule